// File: doc/BRIEF.md
# Floppy Controller Host Phase Sequencer

This block is the host-facing side of a simplified floppy-disk controller. A processor talks to it through four byte registers: a status register, a one-byte data port, an output/motor control register and a rate-select register. Every command runs through up to three phases. In the command phase the host writes an opcode and its parameter bytes. In the execution phase the controller works for a fixed number of cycles. In the result phase the host reads back the result bytes. The status register tells the host at every moment whether it may move a byte, and in which direction.

Three commands are understood: Specify (stored timing parameters, no result), Seek (an abstract head move that records the new cylinder per drive and raises an interrupt), and Sense Interrupt (reports and clears one pending drive event). Any other opcode is answered with a single "invalid" byte. A controller reset comes either from holding the reset bit of the output register low, or from a rate-select write with its top bit set. When a reset ends, every drive has a pending event, and each one has to be drained with its own Sense Interrupt. The interrupt line can be masked by a bit in the output register, and the host can then poll instead.

Top module: `fdc_phase_seq`

## Requirements
- R1: The status byte is {bit7 ready-for-transfer, bit6 direction-to-host, bit5 executing, bit4 busy, bits3:0 zero}. It reads 0x80 when idle, 0x90 after an opcode has been taken and parameters are still due, 0x30 during execution and 0xD0 while result bytes are offered.
- R2: A data-port read (address 1) during the result phase returns the current result byte and advances to the next one. A data-port read in any other phase returns 0x00 and changes nothing.
- R3: In the cycle after the last result byte is read, the status is 0x80 again and a new opcode is accepted.
- R4: A data-port write made while the status shows bit7 clear or bit6 set is dropped, and the output wr_err goes high and stays high until a controller reset. The command in progress and its result bytes are not disturbed.
- R5: While output-register (address 2) bit 2 is 0 the controller is held in reset and the status reads 0x00. Setting bit 2 again, or writing the rate register (address 3) with bit 7 set, resets the controller. One cycle after the reset ends, the interrupt is pending and all four drives have a reset event pending. Every drive's cylinder reads 0.
- R6: Sense Interrupt (opcode 0x08, no parameters) returns two bytes: st0 and then the drive's cylinder. Reset events come first, lowest drive first, with st0 = 0xC0 | drive. Seek events come next, lowest drive first, with st0 = 0x20 | drive. The event reported is cleared. With nothing pending, the single byte 0x80 is returned.
- R7: The irq output equals the internal pending flag ANDed with output-register bit 3. The flag is cleared when a Sense Interrupt opcode is accepted.
- R8: Seek (opcode 0x0F) takes two parameters: the drive in bits 1:0 of the first byte and the target cylinder as the second byte. After the second byte, the status reads 0x30 for exactly EXEC_CYC cycles and then 0x80. At that point the interrupt is pending and the drive's cylinder equals the target.
- R9: Specify (opcode 0x03) takes two parameter bytes and returns to status 0x80 straight after the second one. There is no execution phase, no result and no interrupt.
- R10: Any opcode other than 0x03, 0x08 and 0x0F goes straight to the result phase (status 0xD0) and offers the single byte 0x80.
- R11: A rate-register write sets the rate output to bits 1:0 of the written byte (3 = 1 Mbps, 1 = 300 kbps, 2 = 250 kbps, which is the power-on value). It raises no interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| wr_en | input | 1 | Host register write strobe |
| rd_en | input | 1 | Host register read strobe (advances result bytes on address 1) |
| addr | input | 2 | Register select: 0 status, 1 data, 2 output/motor, 3 rate |
| wdata | input | 8 | Host write data |
| rdata | output | 8 | Host read data (combinational from addr) |
| irq | output | 1 | Completion interrupt, masked by output-register bit 3 |
| wr_err | output | 1 | Sticky flag for a data write made at the wrong time |
| drate | output | 2 | Selected data-rate code |

## Verification
Register writes take effect at the clock edge that samples them. Status and data reads are combinational, so the bench reads them on the falling edge straight after a write task returns. An execution phase starts at the edge that takes the last Seek parameter. The bench checks that the status still reads 0x30 after EXEC_CYC-1 further edges and reads 0x80, with irq high, one edge later. A reset release shows up in irq one edge after the release edge, because the controller spends one armed cycle before setting its pending events. A rate-register reset takes one extra edge for its registered pulse, so the bench sees status 0x00, then 0x80 with irq low, then irq high.

// File: rtl/fdc_pkg.sv
package fdc_pkg;

    typedef enum logic [1:0] {
        PH_CMD  = 2'd0,
        PH_EXEC = 2'd1,
        PH_RES  = 2'd2
    } phase_t;

    typedef enum logic [1:0] {
        RG_STATUS = 2'd0,
        RG_DATA   = 2'd1,
        RG_MOTOR  = 2'd2,
        RG_RATE   = 2'd3
    } reg_sel_t;

    typedef struct packed {
        logic       rqm;
        logic       dio;
        logic       ndma;
        logic       busy;
        logic [3:0] rsvd;
    } status_t;

    localparam logic [7:0] OP_SPECIFY  = 8'h03;
    localparam logic [7:0] OP_SENSE    = 8'h08;
    localparam logic [7:0] OP_SEEK     = 8'h0F;
    localparam logic [7:0] RES_INVALID = 8'h80;
    localparam logic [7:0] ST0_RESET   = 8'hC0;
    localparam logic [7:0] ST0_SEEK    = 8'h20;
    localparam int         RES_MAX     = 2;

    localparam int MOTOR_RST_BIT = 2;
    localparam int MOTOR_IRQ_BIT = 3;
    localparam int RATE_RST_BIT  = 7;

    function automatic logic [1:0] param_count(input logic [7:0] op);
        return (op == OP_SPECIFY || op == OP_SEEK) ? 2'd2 : 2'd0;
    endfunction

    function automatic status_t phase_status(input phase_t ph, input logic busy, input logic held);
        status_t s;
        s = '0;
        if (!held) begin
            unique case (ph)
                PH_CMD:  begin s.rqm = 1'b1; s.busy = busy; end
                PH_EXEC: begin s.ndma = 1'b1; s.busy = 1'b1; end
                PH_RES:  begin s.rqm = 1'b1; s.dio = 1'b1; s.busy = 1'b1; end
                default: s = '0;
            endcase
        end
        return s;
    endfunction

endpackage

// File: rtl/fdc_host_regs.sv
module fdc_host_regs
    import fdc_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_en,
    input  logic       rd_en,
    input  logic [1:0] addr,
    input  logic [7:0] wdata,
    output logic [7:0] motor_q,
    output logic [1:0] rate_q,
    output logic       hold,
    output logic       dat_wr,
    output logic       dat_rd
);
    logic     rate_kick;
    reg_sel_t sel;

    assign sel    = reg_sel_t'(addr);
    assign dat_wr = wr_en && (sel == RG_DATA);
    assign dat_rd = rd_en && (sel == RG_DATA);
    assign hold   = !motor_q[MOTOR_RST_BIT] || rate_kick;

    always_ff @(posedge clk) begin
        if (rst) begin
            motor_q   <= '0;
            rate_q    <= 2'd2;
            rate_kick <= 1'b0;
        end else begin
            rate_kick <= 1'b0;
            if (wr_en && sel == RG_MOTOR) begin
                motor_q <= wdata;
            end
            if (wr_en && sel == RG_RATE) begin
                rate_q    <= wdata[1:0];
                rate_kick <= wdata[RATE_RST_BIT];
            end
        end
    end

endmodule

// File: rtl/fdc_phase_fsm.sv
module fdc_phase_fsm
    import fdc_pkg::*;
#(
    parameter int NDRV     = 4,
    parameter int EXEC_CYC = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       hold,
    input  logic       dat_wr,
    input  logic       dat_rd,
    input  logic [7:0] wdata,
    output logic [7:0] status_o,
    output logic [7:0] rd_byte,
    output logic       irq_pend,
    output logic       err_o
);
    localparam int DW = $clog2(NDRV);
    localparam int CW = $clog2(EXEC_CYC);
    localparam int RW = $clog2(RES_MAX);
    localparam logic [CW-1:0] EXEC_LAST = CW'(EXEC_CYC - 1);

    phase_t          phase;
    logic            busy;
    logic [1:0]      pcnt;
    logic [7:0]      opc;
    logic [7:0]      par1;
    logic [7:0]      tgt;
    logic [CW-1:0]   cnt;
    logic [7:0]      res_q [RES_MAX];
    logic [RW-1:0]   res_idx;
    logic [RW-1:0]   res_last;
    logic [NDRV-1:0] rst_pend;
    logic [NDRV-1:0] seek_pend;
    logic [7:0]      pcn [NDRV];
    logic            irq_f;
    logic            err_f;
    logic            armed;

    logic            pick_ok;
    logic            pick_rst;
    logic [DW-1:0]   pick_d;
    logic [DW-1:0]   seek_d;

    assign seek_d   = par1[DW-1:0];
    assign status_o = phase_status(phase, busy, hold);
    assign rd_byte  = (phase == PH_RES && !hold) ? res_q[res_idx] : 8'h00;
    assign irq_pend = irq_f;
    assign err_o    = err_f;

    // Reset events outrank seek events; within each, the lowest drive wins.
    always_comb begin
        pick_ok  = 1'b0;
        pick_rst = 1'b0;
        pick_d   = '0;
        for (int i = NDRV - 1; i >= 0; i--) begin
            if (seek_pend[i]) begin
                pick_ok = 1'b1;
                pick_d  = DW'(i);
            end
        end
        for (int i = NDRV - 1; i >= 0; i--) begin
            if (rst_pend[i]) begin
                pick_ok  = 1'b1;
                pick_rst = 1'b1;
                pick_d   = DW'(i);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst || hold) begin
            phase     <= PH_CMD;
            busy      <= 1'b0;
            pcnt      <= '0;
            opc       <= '0;
            par1      <= '0;
            tgt       <= '0;
            cnt       <= '0;
            res_idx   <= '0;
            res_last  <= '0;
            rst_pend  <= '0;
            seek_pend <= '0;
            irq_f     <= 1'b0;
            err_f     <= 1'b0;
            armed     <= 1'b1;
            for (int i = 0; i < RES_MAX; i++) res_q[i] <= '0;
            for (int i = 0; i < NDRV; i++) pcn[i] <= '0;
        end else begin
            if (armed) begin
                armed    <= 1'b0;
                rst_pend <= '1;
                irq_f    <= 1'b1;
            end
            unique case (phase)
                PH_CMD: begin
                    if (dat_wr && !busy) begin
                        opc     <= wdata;
                        busy    <= 1'b1;
                        res_idx <= '0;
                        if (param_count(wdata) != 2'd0) begin
                            pcnt <= param_count(wdata);
                        end else if (wdata == OP_SENSE) begin
                            irq_f <= 1'b0;
                            phase <= PH_RES;
                            if (pick_ok) begin
                                res_q[0] <= (pick_rst ? ST0_RESET : ST0_SEEK) | 8'(pick_d);
                                res_q[1] <= pcn[pick_d];
                                res_last <= RW'(1);
                                if (pick_rst) rst_pend[pick_d]  <= 1'b0;
                                else          seek_pend[pick_d] <= 1'b0;
                            end else begin
                                res_q[0] <= RES_INVALID;
                                res_last <= '0;
                            end
                        end else begin
                            phase    <= PH_RES;
                            res_q[0] <= RES_INVALID;
                            res_last <= '0;
                        end
                    end else if (dat_wr) begin
                        pcnt <= pcnt - 2'd1;
                        if (pcnt == 2'd2) begin
                            par1 <= wdata;
                        end else if (opc == OP_SEEK) begin
                            tgt   <= wdata;
                            cnt   <= '0;
                            phase <= PH_EXEC;
                        end else begin
                            busy <= 1'b0;
                        end
                    end
                end
                PH_EXEC: begin
                    if (dat_wr) err_f <= 1'b1;
                    if (cnt == EXEC_LAST) begin
                        phase             <= PH_CMD;
                        busy              <= 1'b0;
                        pcn[seek_d]       <= tgt;
                        seek_pend[seek_d] <= 1'b1;
                        irq_f             <= 1'b1;
                    end else begin
                        cnt <= cnt + CW'(1);
                    end
                end
                PH_RES: begin
                    if (dat_wr) err_f <= 1'b1;
                    if (dat_rd) begin
                        if (res_idx == res_last) begin
                            phase   <= PH_CMD;
                            busy    <= 1'b0;
                            res_idx <= '0;
                        end else begin
                            res_idx <= res_idx + RW'(1);
                        end
                    end
                end
                default: phase <= PH_CMD;
            endcase
        end
    end

    AST_RES_EXIT: assert property (@(posedge clk) disable iff (rst)
        (!hold && phase == PH_RES && dat_rd && res_idx == res_last) |=> (status_o == 8'h80 || hold)); // R3

    AST_BAD_WR_FLAGS: assert property (@(posedge clk) disable iff (rst)
        (!hold && dat_wr && phase != PH_CMD) |=> err_f); // R4

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
        (err_f && !hold) |=> err_f); // R4

    AST_RELEASE_PEND: assert property (@(posedge clk) disable iff (rst)
        (armed && !hold && !dat_wr) |=> (irq_f && rst_pend == '1)); // R5

    AST_SENSE_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (!hold && !armed && phase == PH_CMD && !busy && dat_wr && wdata == OP_SENSE)
        |=> (!irq_f && phase == PH_RES)); // R7

    AST_EXEC_DONE: assert property (@(posedge clk) disable iff (rst)
        (!hold && phase == PH_EXEC && cnt == EXEC_LAST) |=> (irq_f && phase == PH_CMD)); // R8

endmodule

// File: rtl/fdc_phase_seq.sv
module fdc_phase_seq
    import fdc_pkg::*;
#(
    parameter int NDRV     = 4,
    parameter int EXEC_CYC = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_en,
    input  logic       rd_en,
    input  logic [1:0] addr,
    input  logic [7:0] wdata,
    output logic [7:0] rdata,
    output logic       irq,
    output logic       wr_err,
    output logic [1:0] drate
);
    logic [7:0] motor_q;
    logic [1:0] rate_q;
    logic       hold;
    logic       dat_wr;
    logic       dat_rd;
    logic [7:0] status_b;
    logic [7:0] rd_byte;
    logic       irq_pend;

    fdc_host_regs u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .rd_en   (rd_en),
        .addr    (addr),
        .wdata   (wdata),
        .motor_q (motor_q),
        .rate_q  (rate_q),
        .hold    (hold),
        .dat_wr  (dat_wr),
        .dat_rd  (dat_rd)
    );

    fdc_phase_fsm #(
        .NDRV     (NDRV),
        .EXEC_CYC (EXEC_CYC)
    ) u_fsm (
        .clk      (clk),
        .rst      (rst),
        .hold     (hold),
        .dat_wr   (dat_wr),
        .dat_rd   (dat_rd),
        .wdata    (wdata),
        .status_o (status_b),
        .rd_byte  (rd_byte),
        .irq_pend (irq_pend),
        .err_o    (wr_err)
    );

    assign irq   = irq_pend && motor_q[MOTOR_IRQ_BIT];
    assign drate = rate_q;

    always_comb begin
        unique case (reg_sel_t'(addr))
            RG_STATUS: rdata = status_b;
            RG_DATA:   rdata = rd_byte;
            RG_MOTOR:  rdata = motor_q;
            RG_RATE:   rdata = {6'd0, rate_q};
            default:   rdata = 8'h00;
        endcase
    end

endmodule

// File: tb/sim_fdc_phase_seq.sv
module sim_fdc_phase_seq;
    localparam int EXC = 4;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic       rd_en = 1'b0;
    logic [1:0] addr = 2'd0;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata;
    logic       irq;
    logic       wr_err;
    logic [1:0] drate;

    int total = 0;
    int bad = 0;

    always #5 clk = ~clk;

    fdc_phase_seq #(.NDRV(4), .EXEC_CYC(EXC)) u0 (
        .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .irq(irq), .wr_err(wr_err), .drate(drate)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0; addr = 2'd0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] v);
        @(negedge clk);
        rd_en = 1'b1; addr = a;
        #1 v = rdata;
        @(negedge clk);
        rd_en = 1'b0; addr = 2'd0;
    endtask

    task automatic peek(input logic [1:0] a, output logic [7:0] v);
        addr = a;
        #1 v = rdata;
        addr = 2'd0;
    endtask

    task automatic sense(input string tag, input logic [7:0] e0, input logic [7:0] e1, input bit two);
        logic [7:0] v;
        wr(2'd1, 8'h08);
        peek(2'd0, v); chk({tag, " R1 result status"}, v, 8'hD0);
        chk({tag, " R7 irq cleared by sense"}, {7'd0, irq}, 8'h00);
        rd(2'd1, v); chk({tag, " R6 st0"}, v, e0);
        if (two) begin
            rd(2'd1, v); chk({tag, " R6 cylinder"}, v, e1);
        end
        peek(2'd0, v); chk({tag, " R3 back to idle"}, v, 8'h80);
    endtask

    task automatic seek(input logic [1:0] d, input logic [7:0] cyl, input bit irq_exp);
        logic [7:0] v;
        wr(2'd1, 8'h0F);
        peek(2'd0, v); chk("R1 busy awaiting params", v, 8'h90);
        wr(2'd1, {6'd0, d});
        wr(2'd1, cyl);
        peek(2'd0, v); chk("R8 exec start", v, 8'h30);
        step(EXC - 1);
        peek(2'd0, v); chk("R8 exec last cycle", v, 8'h30);
        step(1);
        peek(2'd0, v); chk("R8 exec over", v, 8'h80);
        chk("R8 irq after seek", {7'd0, irq}, {7'd0, irq_exp});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        $display("FAIL watchdog act=running exp=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [7:0] v;
        step(3);
        rst = 1'b0;
        step(1);

        // R5: held in reset after power-on
        peek(2'd0, v); chk("R5 held status", v, 8'h00);
        chk("R5 no irq while held", {7'd0, irq}, 8'h00);
        chk("R11 default rate", {6'd0, drate}, 8'h02);
        chk("R4 err clear at start", {7'd0, wr_err}, 8'h00);

        wr(2'd2, 8'h0C);
        peek(2'd0, v); chk("R5 released status", v, 8'h80);
        chk("R5 irq one cycle later (armed)", {7'd0, irq}, 8'h00);
        step(1);
        chk("R5 irq after release", {7'd0, irq}, 8'h01);

        // R6: four reset events, lowest drive first
        for (int d = 0; d < 4; d++) sense("reset", 8'hC0 | 8'(d), 8'h00, 1'b1);
        sense("empty", 8'h80, 8'h00, 1'b0);

        // R2: read outside result phase
        rd(2'd1, v); chk("R2 idle data read", v, 8'h00);
        peek(2'd0, v); chk("R2 idle read no effect", v, 8'h80);

        // R10: sweep all unknown opcodes
        for (int op = 0; op < 256; op++) begin
            if (op == 8'h03 || op == 8'h08 || op == 8'h0F) continue;
            wr(2'd1, 8'(op));
            peek(2'd0, v); chk("R10 invalid result phase", v, 8'hD0);
            rd(2'd1, v); chk("R10 invalid byte", v, 8'h80);
            peek(2'd0, v); chk("R3 after invalid", v, 8'h80);
        end

        // R9: specify
        wr(2'd1, 8'h03);
        peek(2'd0, v); chk("R9 specify busy", v, 8'h90);
        wr(2'd1, 8'hAF);
        peek(2'd0, v); chk("R9 specify mid", v, 8'h90);
        wr(2'd1, 8'h02);
        peek(2'd0, v); chk("R9 specify done", v, 8'h80);
        chk("R9 no irq", {7'd0, irq}, 8'h00);

        // R8/R6: seek sweep over drives and cylinders
        for (int d = 0; d < 4; d++) begin
            for (int k = 0; k < 3; k++) begin
                logic [7:0] cyl;
                cyl = 8'(d * 37 + k * 61 + 1);
                seek(2'(d), cyl, 1'b1);
                sense("seek", 8'h20 | 8'(d), cyl, 1'b1);
            end
        end

        // R6: seek events drained lowest drive first
        seek(2'd3, 8'h09, 1'b1);
        seek(2'd1, 8'h04, 1'b1);
        sense("order1", 8'h21, 8'h04, 1'b1);
        sense("order2", 8'h23, 8'h09, 1'b1);

        // R7: interrupt masked by output-register bit 3
        wr(2'd2, 8'h04);
        seek(2'd2, 8'h33, 1'b0);
        wr(2'd2, 8'h0C);
        chk("R7 irq unmasked", {7'd0, irq}, 8'h01);
        sense("masked", 8'h22, 8'h33, 1'b1);

        // R4: wrong-time writes
        wr(2'd1, 8'h0F);
        wr(2'd1, 8'h00);
        wr(2'd1, 8'h44);
        wr(2'd1, 8'h55);
        chk("R4 err after exec write", {7'd0, wr_err}, 8'h01);
        step(EXC);
        peek(2'd0, v); chk("R4 exec unaffected", v, 8'h80);
        wr(2'd1, 8'h08);
        wr(2'd1, 8'h99);
        peek(2'd0, v); chk("R4 still result phase", v, 8'hD0);
        rd(2'd1, v); chk("R4 st0 intact", v, 8'h20);
        rd(2'd1, v); chk("R4 cylinder intact", v, 8'h44);
        step(3);
        chk("R4 err sticky", {7'd0, wr_err}, 8'h01);

        // R11: rate write
        wr(2'd3, 8'h03);
        chk("R11 rate 1M", {6'd0, drate}, 8'h03);
        chk("R11 no irq", {7'd0, irq}, 8'h00);
        peek(2'd0, v); chk("R11 status unchanged", v, 8'h80);
        rd(2'd3, v); chk("R11 rate readback", v, 8'h03);

        // R5: reset through the rate register
        wr(2'd3, 8'h81);
        peek(2'd0, v); chk("R5 rate reset held", v, 8'h00);
        chk("R11 rate 300k", {6'd0, drate}, 8'h01);
        step(1);
        peek(2'd0, v); chk("R5 rate reset released", v, 8'h80);
        chk("R5 irq not yet", {7'd0, irq}, 8'h00);
        chk("R4 err cleared by reset", {7'd0, wr_err}, 8'h00);
        step(1);
        chk("R5 irq after rate reset", {7'd0, irq}, 8'h01);
        for (int d = 0; d < 4; d++) sense("rreset", 8'hC0 | 8'(d), 8'h00, 1'b1);
        sense("rempty", 8'h80, 8'h00, 1'b0);

        // R5: reset through output-register bit 2 clears cylinders
        seek(2'd0, 8'h17, 1'b1);
        wr(2'd2, 8'h08);
        peek(2'd0, v); chk("R5 bit2 low held", v, 8'h00);
        wr(2'd2, 8'h0C);
        step(1);
        chk("R5 irq after bit2 reset", {7'd0, irq}, 8'h01);
        for (int d = 0; d < 4; d++) sense("dreset", 8'hC0 | 8'(d), 8'h00, 1'b1);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule